// File: doc/BRIEF.md
# Oversampled Asynchronous Frame Codec

This block sits between a synchronous serial port that moves 16-bit words and a slow asynchronous device. The device runs at one sixteenth of the port's bit rate, so each of its bit periods lasts exactly sixteen port samples. The block does no clock division. It widens each slow bit into a whole 16-sample word, and it narrows captured sample words back into bits.

On the transmit side, a byte accepted through a valid/ready handshake becomes a ten-word burst on a valid/ready word stream:

- one all-zero start word;
- eight data words, least significant bit first;
- one all-ones stop word.

On the receive side, the block watches a one-bit sample line that is qualified by a sample enable. A falling edge arms capture. Nine bit periods (144 samples) are packed into words, and the first word, which is the start bit, is thrown away. Each of the remaining eight words becomes one data bit by a majority vote over its eight centre samples. The recovered byte is shown with a single-cycle strobe.

Top module: `fcodec_top`

## Requirements
- R1: A transmitted frame is exactly ten words on the word stream. The first word is 16'h0000 and the last is 16'hFFFF, and the stream goes idle after the last word is taken.
- R2: Transmitted words 2 to 9 carry the byte least significant bit first. A 0 bit becomes 16'h0000 and a 1 bit becomes 16'hFFFF.
- R3: `tx_ready` is low from the cycle after a byte is accepted until the stop word has been taken. While `txw_valid` is high and `txw_ready` is low, `txw_data` holds its value.
- R4: Receive capture starts on an enabled sample of 0 whose preceding enabled sample was 1. The line idles high after reset.
- R5: The capture spans 144 enabled samples, with the edge sample counted as sample 0. Samples 0 to 15 (the start bit) never affect the result, even if some of them are 1.
- R6: Data bit i (LSB first) comes from samples 16(i+1)+4 to 16(i+1)+11 of the capture. The bit is 1 when at least 5 of those 8 samples are 1. The outer 8 samples of each group are ignored.
- R7: `rx_valid` is high for exactly one cycle: the cycle after the clock edge that takes the 144th sample. `rx_byte` holds the byte during that cycle.
- R8: Falling edges on the line inside a capture do not start a new capture. Each frame gives exactly one `rx_valid` pulse.
- R9: After reset, `tx_ready` is 1, `txw_valid` is 0 and `rx_valid` is 0.
- R10: The line is only looked at in cycles where `rx_sample_en` is high. Line changes in other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_byte | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Block can take a byte |
| txw_data | output | 16 | Word toward the serial port |
| txw_valid | output | 1 | Word offered |
| txw_ready | input | 1 | Serial port takes the word |
| rx_line | input | 1 | Incoming sample value |
| rx_sample_en | input | 1 | Sample qualifier |
| rx_byte | output | 8 | Recovered byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |

## Verification
The first transmit word appears in the cycle after the byte handshake. Each later word appears in the cycle after the previous word's handshake. The bench therefore samples the word stream on the falling edge before each handshake edge, and it also samples during deliberate stall cycles.

The received byte and its strobe are due in the cycle that follows the edge taking the 144th sample. The bench checks the strobe on the first falling edge after that sample and checks that it is gone one falling edge later.

A pulse counter, also sampled on falling edges, confirms that each frame gives exactly one strobe. This holds even when the frame contains falling edges or has gaps in the sample enable.

// File: rtl/fcodec_pkg.sv
package fcodec_pkg;

    localparam int SPB       = 16;                 // samples per slow bit
    localparam int DBITS     = 8;                  // data bits per frame
    localparam int CENTRE    = 8;                  // samples voted per bit
    localparam int VOTE_MIN  = CENTRE / 2 + 1;     // strict majority
    localparam int CLO       = (SPB - CENTRE) / 2; // first voted sample bit
    localparam int CHI       = CLO + CENTRE - 1;   // last voted sample bit
    localparam int TX_WORDS  = DBITS + 2;          // start + data + stop
    localparam int RX_WORDS  = DBITS + 1;          // start + data

    typedef logic [SPB-1:0]   word_t;
    typedef logic [DBITS-1:0] byte_t;

    function automatic word_t bit_to_word(input logic b);
        return {SPB{b}};
    endfunction

    function automatic logic centre_vote(input word_t w);
        int ones;
        ones = 0;
        for (int i = CLO; i <= CHI; i++) ones += int'(w[i]);
        return ones >= VOTE_MIN;
    endfunction

endpackage

// File: rtl/fcodec_tx.sv
module fcodec_tx
    import fcodec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t byte_i,
    input  logic  byte_valid_i,
    output logic  byte_ready_o,
    output word_t word_o,
    output logic  word_valid_o,
    input  logic  word_ready_i
);
    localparam int IW = $clog2(TX_WORDS);
    localparam logic [IW-1:0] LAST = IW'(TX_WORDS - 1);

    logic          busy;
    logic [IW-1:0] idx;
    byte_t         sh;

    assign byte_ready_o = !busy;
    assign word_valid_o = busy;

    always_comb begin
        if (idx == '0)       word_o = '0;
        else if (idx == LAST) word_o = '1;
        else                  word_o = bit_to_word(sh[0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
            sh   <= '0;
        end else if (!busy) begin
            if (byte_valid_i) begin
                busy <= 1'b1;
                idx  <= '0;
                sh   <= byte_i;
            end
        end else if (word_ready_i) begin
            if (idx == LAST) busy <= 1'b0;
            else             idx  <= idx + 1'b1;
            if (idx != '0)   sh   <= sh >> 1;
        end
    end

    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (word_valid_o && !word_ready_i) |=> (word_valid_o && $stable(word_o)));

    assert_tx_start_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(word_valid_o) |-> (word_o == '0));

    assert_tx_stop_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(word_valid_o) |-> ($past(word_o) == '1));

    assert_tx_level_R2: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> (word_o == '0 || word_o == '1));

endmodule

// File: rtl/fcodec_rx_frame.sv
module fcodec_rx_frame
    import fcodec_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       line_i,
    input  logic                       sample_en_i,
    output word_t                      word_o,
    output logic                       word_valid_o,
    output logic [$clog2(DBITS)-1:0]   bit_idx_o,
    output logic                       last_o
);
    localparam int SW = $clog2(SPB);
    localparam int WW = $clog2(RX_WORDS);
    localparam int BW = $clog2(DBITS);

    logic          prev;
    logic          active;
    logic [SW-1:0] spos;
    logic [WW-1:0] widx;
    word_t         sh;
    word_t         full;
    logic          word_done;

    assign full         = {sh[SPB-2:0], line_i};
    assign word_done    = active && sample_en_i && (spos == SW'(SPB - 1));
    assign word_valid_o = word_done && (widx != '0);
    assign word_o       = full;
    assign bit_idx_o    = BW'(widx - 1'b1);
    assign last_o       = (widx == WW'(DBITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= 1'b1;
            active <= 1'b0;
            spos   <= '0;
            widx   <= '0;
            sh     <= '0;
        end else if (sample_en_i) begin
            prev <= line_i;
            if (active) begin
                sh   <= full;
                spos <= (spos == SW'(SPB - 1)) ? '0 : spos + 1'b1;
                if (word_done) begin
                    widx <= widx + 1'b1;
                    if (widx == WW'(DBITS)) active <= 1'b0;
                end
            end else if (prev && !line_i) begin
                active <= 1'b1;
                spos   <= SW'(1);
                widx   <= '0;
                sh     <= '0;
            end
        end
    end

    assert_rx_edge_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> ($past(prev) && !$past(line_i) && $past(sample_en_i)));

    assert_rx_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (active && !(word_done && last_o)) |=> active);

    assert_rx_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !sample_en_i |=> ($stable(spos) && $stable(active) && $stable(widx)));

endmodule

// File: rtl/fcodec_rx_vote.sv
module fcodec_rx_vote
    import fcodec_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  word_t                    word_i,
    input  logic                     word_valid_i,
    input  logic [$clog2(DBITS)-1:0] bit_idx_i,
    input  logic                     last_i,
    output byte_t                    byte_o,
    output logic                     valid_o
);
    byte_t acc;
    byte_t nxt;

    always_comb begin
        nxt            = acc;
        nxt[bit_idx_i] = centre_vote(word_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            byte_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (word_valid_i) begin
                acc <= nxt;
                if (last_i) begin
                    byte_o  <= nxt;
                    valid_o <= 1'b1;
                end
            end
        end
    end

    assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

endmodule

// File: rtl/fcodec_top.sv
module fcodec_top
    import fcodec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  tx_byte,
    input  logic        tx_valid,
    output logic        tx_ready,
    output logic [15:0] txw_data,
    output logic        txw_valid,
    input  logic        txw_ready,
    input  logic        rx_line,
    input  logic        rx_sample_en,
    output logic [7:0]  rx_byte,
    output logic        rx_valid
);
    word_t                    rw_word;
    logic                     rw_valid;
    logic [$clog2(DBITS)-1:0] rw_idx;
    logic                     rw_last;

    fcodec_tx u_tx (
        .clk          (clk),
        .rst          (rst),
        .byte_i       (tx_byte),
        .byte_valid_i (tx_valid),
        .byte_ready_o (tx_ready),
        .word_o       (txw_data),
        .word_valid_o (txw_valid),
        .word_ready_i (txw_ready)
    );

    fcodec_rx_frame u_rx_frame (
        .clk          (clk),
        .rst          (rst),
        .line_i       (rx_line),
        .sample_en_i  (rx_sample_en),
        .word_o       (rw_word),
        .word_valid_o (rw_valid),
        .bit_idx_o    (rw_idx),
        .last_o       (rw_last)
    );

    fcodec_rx_vote u_rx_vote (
        .clk          (clk),
        .rst          (rst),
        .word_i       (rw_word),
        .word_valid_i (rw_valid),
        .bit_idx_i    (rw_idx),
        .last_i       (rw_last),
        .byte_o       (rx_byte),
        .valid_o      (rx_valid)
    );

    assert_reset_R9: assert property (@(posedge clk)
        $past(rst) |-> (tx_ready && !txw_valid && !rx_valid));

endmodule

// File: tb/fcodec_top_tb_top.sv
module fcodec_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  tx_byte = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [15:0] txw_data;
    logic        txw_valid;
    logic        txw_ready = 1'b0;
    logic        rx_line = 1'b1;
    logic        rx_sample_en = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_valid;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fcodec_top dut_i (.*);

    always @(negedge clk) if (!rst && rx_valid) pulses++;

    localparam logic [7:0] LOOP_VEC [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    // {sample group, expected voted bit}
    localparam logic [16:0] VOTE_VEC [8] = '{
        {16'h0FF0, 1'b1}, {16'hF00F, 1'b0}, {16'h0F00, 1'b0}, {16'h0F80, 1'b1},
        {16'hFFFF, 1'b1}, {16'h0000, 1'b0}, {16'h0AA0, 1'b0}, {16'h0AB0, 1'b1}};

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        chk(tx_ready == 1'b1, "R3", 16'(tx_ready), 16'd1);
        tx_valid = 1'b1;
        tx_byte  = b;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R3", 16'(tx_ready), 16'd0);
    endtask

    // takes the ten words, stalling on odd ones, returns them packed
    task automatic take_frame(input logic [7:0] b, output logic [159:0] fr);
        logic [15:0] exp;
        for (int k = 0; k < 10; k++) begin
            if (k == 0) exp = 16'h0000;
            else if (k == 9) exp = 16'hFFFF;
            else exp = b[k-1] ? 16'hFFFF : 16'h0000;
            chk(txw_valid == 1'b1, "R1", 16'(txw_valid), 16'd1);
            chk(txw_data == exp, (k == 0 || k == 9) ? "R1" : "R2", txw_data, exp);
            fr[159-16*k -: 16] = txw_data;
            if (k % 2 == 1) begin
                @(negedge clk);
                chk(txw_data == exp, "R3", txw_data, exp);
            end
            txw_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            txw_ready = 1'b0;
        end
        chk(txw_valid == 1'b0, "R1", 16'(txw_valid), 16'd0);
        chk(tx_ready == 1'b1, "R3", 16'(tx_ready), 16'd1);
    endtask

    // feeds idle, then 144 frame samples MSB first; checks strobe timing and byte
    task automatic feed(input logic [143:0] fr, input bit gap, input logic [7:0] exp);
        int p0;
        p0 = pulses;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); rx_sample_en = 1'b1; rx_line = 1'b1;
        end
        for (int i = 0; i < 144; i++) begin
            if (gap && (i % 7 == 3)) begin
                @(negedge clk); rx_sample_en = 1'b0; rx_line = ~fr[143-i];
            end
            @(negedge clk); rx_sample_en = 1'b1; rx_line = fr[143-i];
        end
        @(negedge clk);
        rx_sample_en = 1'b0; rx_line = 1'b1;
        chk(rx_valid == 1'b1, "R7", 16'(rx_valid), 16'd1);
        chk(rx_byte == exp, "R6", 16'(rx_byte), 16'(exp));
        @(negedge clk);
        chk(rx_valid == 1'b0, "R7", 16'(rx_valid), 16'd0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); rx_sample_en = 1'b1; rx_line = 1'b1;
        end
        rx_sample_en = 1'b0;
        chk(pulses - p0 == 1, "R8", 16'(pulses - p0), 16'd1);
    endtask

    initial begin
        logic [159:0] txf;
        logic [143:0] rf;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R9 reset state
        chk(tx_ready == 1'b1, "R9", 16'(tx_ready), 16'd1);
        chk(txw_valid == 1'b0, "R9", 16'(txw_valid), 16'd0);
        chk(rx_valid == 1'b0, "R9", 16'(rx_valid), 16'd0);

        // vector table: transmit each byte, loop its words back into receive (R1 R2 R4 R6)
        foreach (LOOP_VEC[v]) begin
            send_byte(LOOP_VEC[v]);
            take_frame(LOOP_VEC[v], txf);
            feed(txf[159:16], 1'b0, LOOP_VEC[v]);
        end

        // R6 majority corners; 0x0AA0 groups also carry edges inside the frame (R8)
        rf[143:128] = 16'h0000;
        for (int g = 0; g < 8; g++) rf[127-16*g -: 16] = VOTE_VEC[g][16:1];
        begin
            logic [7:0] e;
            for (int g = 0; g < 8; g++) e[g] = VOTE_VEC[g][0];
            feed(rf, 1'b0, e);
            for (int g = 0; g < 8; g++)
                chk(rx_byte[g] == e[g], "R6", 16'(rx_byte[g]), 16'(e[g]));
        end

        // R5 start word contents are dropped
        rf = '0;
        rf[143:128] = 16'h0FF0;
        rf[127:112] = 16'hFFFF;
        feed(rf, 1'b0, 8'h01);

        // R10 gaps in the sample enable with the line flipped during gaps
        for (int g = 0; g < 8; g++) rf[127-16*g -: 16] = (8'h3C >> g) & 1 ? 16'hFFFF : 16'h0000;
        rf[143:128] = 16'h0000;
        feed(rf, 1'b1, 8'h3C);

        // R10 line activity with enable low starts nothing
        begin
            int p0;
            p0 = pulses;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk); rx_sample_en = 1'b0; rx_line = i[0];
            end
            rx_line = 1'b1;
            chk(pulses == p0, "R10", 16'(pulses - p0), 16'd0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule